// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Front End

This block is the bus-facing front end of a small byte-addressed nonvolatile memory. It watches a two-wire serial clock and data pair that has already been brought into the system clock domain. It finds start and stop conditions and assembles bytes most significant bit first. It answers with acknowledge and read data through an active-low open-drain enable. It also turns the byte stream into plain strobes for the storage array and the page protection logic that sit beside it.

After a start, the host sends a command byte. The upper nibble must be the device tag and bit 0 selects read or write. A write command is followed by an address byte that loads a shared address counter, and then by data bytes that are handed to the storage side one at a time. A stop after data asks the storage side to program. A read command streams bytes from the counter onward for as long as the host acknowledges. A write command with an address, then a repeated start and a second write command, marks the next byte as a protection control byte. The bytes after it are forwarded as protection data. While the storage side reports a programming cycle, command bytes are left unacknowledged, so the host can poll for completion.

Top module: `serialMemFront`

## Requirements
- R1: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. Bytes clocked without a preceding start are ignored and get no acknowledge.
- R2: A command byte is acknowledged (SDA pulled low in the ninth SCL slot) only when its bits 7..4 equal 4'b1010. Bits 3..1 are ignored and bit 0 selects read (1) or write (0). Any other tag gets no acknowledge.
- R3: The first byte after an acknowledged write command is acknowledged and loads the address counter. The counter is cleared by reset.
- R4: Each later write byte is acknowledged and presented once on memWrData with loadStb high and memAddr equal to its target. The counter then advances within the 8-byte page (address bits 2..0 wrap, the upper bits are kept).
- R5: A stop that ends a write with at least one data byte gives one commitStb pulse. A stop after a read, or after a repeated start that abandoned the data, gives none.
- R6: A write command and address byte, followed by a repeated start and a read command, returns the byte at the loaded address first.
- R7: A read command with no preceding address byte starts at the current counter value. Each byte sent pulses readStb and advances the counter by one, rolling over from the top address to 0.
- R8: A read ends when the host leaves SDA high in the acknowledge slot. No further byte is fetched and SDA is released until the next start.
- R9: While memBusy is high, a command byte of either direction is not acknowledged and the transfer is ignored. Once memBusy is low, the next command is acknowledged.
- R10: A write command and address, then a repeated start and a write command, make the next byte a protection control byte (protCtlStb, value on memWrData). Every following byte pulses protDataStb, and the closing stop pulses protCommitStb instead of commitStb.
- R11: sdaOe is 0 in reset and changes only while SCL is low. The block never drives SDA high.
- R12: A start in the middle of a byte restarts bit counting and makes the next byte a command byte. The abandoned byte produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Serial clock, already synchronized |
| sdaIn | input | 1 | Serial data line level, already synchronized |
| memBusy | input | 1 | Storage side is in a programming cycle |
| memRdData | input | 8 | Storage byte at memAddr, read combinationally |
| sdaOe | output | 1 | Pull SDA low when 1 |
| memAddr | output | AW | Shared address counter |
| memWrData | output | 8 | Last received byte |
| loadStb | output | 1 | Write byte ready for the page buffer |
| commitStb | output | 1 | Start the programming cycle |
| readStb | output | 1 | Byte at memAddr is taken for transmission |
| protCtlStb | output | 1 | Protection control byte ready |
| protDataStb | output | 1 | Protection comparison byte ready |
| protCommitStb | output | 1 | Protection sequence closed by a stop |

## Verification
The assertions assume that sclIn and sdaIn are free of glitches and hold each level for at least two system clocks. They also assume that SDA changes while SCL is high only to form a start or a stop, and that the host never makes a start or stop while the block is pulling SDA low. The bench drives every SCL phase for four system clocks and changes its own SDA only while SCL is low, except inside its start and stop tasks. It always ends a read with a not-acknowledge before it issues a stop or a new start. memBusy is changed only while the bus is idle.

// File: rtl/smfPkg.sv
package smfPkg;

  localparam logic [3:0] DEV_TAG = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_ADDR,
    ST_WDATA,
    ST_PCTL,
    ST_PDATA,
    ST_RDATA
  } smfState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic ackSet;
    logic addrLoad;
    logic addrIncPage;
    logic addrIncFull;
    logic txLoad;
    logic txStop;
  } smfCmd_t;

  // datapath -> control events
  typedef struct packed {
    logic       startDet;
    logic       stopDet;
    logic       byteDone;
    logic       ackRise;
    logic       lineLow;
    logic [7:0] rxByte;
  } smfStat_t;

endpackage

// File: rtl/smfDpath.sv
module smfDpath
  import smfPkg::*;
#(
  parameter int AW     = 8,
  parameter int PAGE_W = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          sclIn,
  input  logic          sdaIn,
  input  smfCmd_t       cmd,
  input  logic [7:0]    memRdData,
  output smfStat_t      stat,
  output logic          sdaOe,
  output logic [AW-1:0] memAddr,
  output logic [7:0]    memWrData
);

  localparam int          BYTE_BITS = 8;
  localparam logic [3:0]  LAST_DATA = 4'(BYTE_BITS - 1);
  localparam logic [3:0]  ACK_SLOT  = 4'(BYTE_BITS);
  localparam logic [PAGE_W-1:0] PAGE_ONE = PAGE_W'(1);
  localparam logic [AW-1:0]     FULL_ONE = AW'(1);

  logic          sclQ, sdaQ;
  logic [3:0]    bitCnt;
  logic [6:0]    rxShift;
  logic [7:0]    rxHold;
  logic [7:0]    txByte;
  logic          ackPend, txActive, oeQ;
  logic [AW-1:0] addrCnt;
  logic          sclRise, sclFall, busCond;

  // edge and condition detection on the synchronized lines
  always_comb begin
    sclRise        = sclIn & ~sclQ;
    sclFall        = ~sclIn & sclQ;
    stat.startDet  = sclIn & sclQ & sdaQ & ~sdaIn;
    stat.stopDet   = sclIn & sclQ & ~sdaQ & sdaIn;
    stat.byteDone  = sclRise & (bitCnt == LAST_DATA);
    stat.ackRise   = sclRise & (bitCnt == ACK_SLOT);
    stat.lineLow   = ~sdaIn;
    stat.rxByte    = {rxShift, sdaIn};
    busCond        = stat.startDet | stat.stopDet;
  end

  // bit counter, shifter, acknowledge and transmit drive
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclQ     <= 1'b1;
      sdaQ     <= 1'b1;
      bitCnt   <= '0;
      rxShift  <= '0;
      rxHold   <= '0;
      txByte   <= '0;
      ackPend  <= 1'b0;
      txActive <= 1'b0;
      oeQ      <= 1'b0;
    end else begin
      sclQ <= sclIn;
      sdaQ <= sdaIn;
      if (busCond) begin
        bitCnt   <= '0;
        ackPend  <= 1'b0;
        txActive <= 1'b0;
        oeQ      <= 1'b0;
      end else begin
        if (sclRise) begin
          if (bitCnt == ACK_SLOT) begin
            bitCnt <= '0;
          end else begin
            bitCnt  <= bitCnt + 4'd1;
            rxShift <= {rxShift[5:0], sdaIn};
          end
        end
        if (stat.byteDone) rxHold <= stat.rxByte;
        if (cmd.ackSet)         ackPend <= 1'b1;
        else if (stat.ackRise)  ackPend <= 1'b0;
        if (cmd.txLoad) begin
          txByte   <= memRdData;
          txActive <= 1'b1;
        end else if (cmd.txStop) begin
          txActive <= 1'b0;
        end
        // the drive only moves on a falling SCL edge
        if (sclFall) begin
          if (bitCnt == ACK_SLOT) oeQ <= ackPend;
          else                    oeQ <= txActive & ~txByte[~bitCnt[2:0]];
        end
      end
    end
  end

  // shared address counter: untouched by start and stop
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrCnt <= '0;
    end else if (cmd.addrLoad) begin
      addrCnt <= stat.rxByte[AW-1:0];
    end else if (cmd.addrIncPage) begin
      addrCnt <= {addrCnt[AW-1:PAGE_W], addrCnt[PAGE_W-1:0] + PAGE_ONE};
    end else if (cmd.addrIncFull) begin
      addrCnt <= addrCnt + FULL_ONE;
    end
  end

  assign sdaOe     = oeQ;
  assign memAddr   = addrCnt;
  assign memWrData = rxHold;

endmodule

// File: rtl/smfCtrl.sv
module smfCtrl
  import smfPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  smfStat_t  stat,
  input  logic      memBusy,
  output smfCmd_t   cmd,
  output smfState_t curState,
  output logic      loadStb,
  output logic      commitStb,
  output logic      readStb,
  output logic      protCtlStb,
  output logic      protDataStb,
  output logic      protCommitStb
);

  smfState_t state;
  logic      addrSet;    // address byte seen, no data or read since
  logic      wrPending;  // write data waiting for a stop
  logic      wasData;    // last byte was a write data byte
  logic      rdFetch;    // fetch the next byte to send
  logic      cmdOk;

  assign cmdOk = (stat.rxByte[7:4] == DEV_TAG);

  always_comb begin
    cmd = '0;
    if (!stat.startDet && !stat.stopDet) begin
      if (stat.byteDone) begin
        unique case (state)
          ST_CMD:   cmd.ackSet = cmdOk & ~memBusy;
          ST_ADDR: begin
            cmd.ackSet   = 1'b1;
            cmd.addrLoad = 1'b1;
          end
          ST_WDATA, ST_PCTL, ST_PDATA: cmd.ackSet = 1'b1;
          default: ;
        endcase
      end
      if (stat.ackRise) begin
        cmd.addrIncPage = wasData;
        cmd.txStop      = (state == ST_RDATA) & ~stat.lineLow;
      end
    end
    cmd.txLoad      = rdFetch;
    cmd.addrIncFull = rdFetch;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state         <= ST_IDLE;
      addrSet       <= 1'b0;
      wrPending     <= 1'b0;
      wasData       <= 1'b0;
      rdFetch       <= 1'b0;
      loadStb       <= 1'b0;
      commitStb     <= 1'b0;
      protCtlStb    <= 1'b0;
      protDataStb   <= 1'b0;
      protCommitStb <= 1'b0;
    end else begin
      loadStb       <= 1'b0;
      commitStb     <= 1'b0;
      protCtlStb    <= 1'b0;
      protDataStb   <= 1'b0;
      protCommitStb <= 1'b0;
      rdFetch       <= 1'b0;
      if (stat.startDet) begin
        // addrSet survives so that a repeated start can pick the sequence
        state     <= ST_CMD;
        wrPending <= 1'b0;
        wasData   <= 1'b0;
      end else if (stat.stopDet) begin
        commitStb     <= wrPending;
        protCommitStb <= (state == ST_PDATA);
        state         <= ST_IDLE;
        wrPending     <= 1'b0;
        wasData       <= 1'b0;
        addrSet       <= 1'b0;
      end else begin
        if (stat.byteDone) begin
          unique case (state)
            ST_CMD: begin
              if (!cmdOk || memBusy) begin
                state <= ST_IDLE;
              end else if (stat.rxByte[0]) begin
                state   <= ST_RDATA;
                addrSet <= 1'b0;
              end else if (addrSet) begin
                state   <= ST_PCTL;
                addrSet <= 1'b0;
              end else begin
                state <= ST_ADDR;
              end
            end
            ST_ADDR: begin
              addrSet <= 1'b1;
              state   <= ST_WDATA;
            end
            ST_WDATA: begin
              loadStb   <= 1'b1;
              wrPending <= 1'b1;
              wasData   <= 1'b1;
              addrSet   <= 1'b0;
            end
            ST_PCTL: begin
              protCtlStb <= 1'b1;
              state      <= ST_PDATA;
            end
            ST_PDATA: protDataStb <= 1'b1;
            default: ;
          endcase
        end
        if (stat.ackRise) begin
          wasData <= 1'b0;
          if (state == ST_RDATA) begin
            // the own acknowledge of the command also reads as low here
            if (stat.lineLow) rdFetch <= 1'b1;
            else              state   <= ST_IDLE;
          end
        end
      end
    end
  end

  assign readStb  = rdFetch;
  assign curState = state;

endmodule

// File: rtl/serialMemFront.sv
module serialMemFront
  import smfPkg::*;
#(
  parameter int AW     = 8,
  parameter int PAGE_W = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          sclIn,
  input  logic          sdaIn,
  input  logic          memBusy,
  input  logic [7:0]    memRdData,
  output logic          sdaOe,
  output logic [AW-1:0] memAddr,
  output logic [7:0]    memWrData,
  output logic          loadStb,
  output logic          commitStb,
  output logic          readStb,
  output logic          protCtlStb,
  output logic          protDataStb,
  output logic          protCommitStb
);

  smfCmd_t   cmdBus;
  smfStat_t  statBus;
  smfState_t ctrlState;

  smfCtrl uCtrl (
    .clk           (clk),
    .rstN          (rstN),
    .stat          (statBus),
    .memBusy       (memBusy),
    .cmd           (cmdBus),
    .curState      (ctrlState),
    .loadStb       (loadStb),
    .commitStb     (commitStb),
    .readStb       (readStb),
    .protCtlStb    (protCtlStb),
    .protDataStb   (protDataStb),
    .protCommitStb (protCommitStb)
  );

  smfDpath #(.AW(AW), .PAGE_W(PAGE_W)) uDpath (
    .clk       (clk),
    .rstN      (rstN),
    .sclIn     (sclIn),
    .sdaIn     (sdaIn),
    .cmd       (cmdBus),
    .memRdData (memRdData),
    .stat      (statBus),
    .sdaOe     (sdaOe),
    .memAddr   (memAddr),
    .memWrData (memWrData)
  );

endmodule

// File: rtl/smfChecker.sv
module smfChecker
  import smfPkg::*;
#(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rstN,
  input logic          sclIn,
  input logic          sdaIn,
  input logic          memBusy,
  input logic          sdaOe,
  input logic [AW-1:0] memAddr,
  input logic          loadStb,
  input logic          commitStb,
  input logic          readStb,
  input logic          protCtlStb,
  input logic          protDataStb,
  input logic          protCommitStb,
  input smfState_t     ctrlState
);

  localparam logic [AW-1:0] STEP = AW'(1);

  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (sdaOe != $past(sdaOe)) |-> !$past(sclIn)) else $error("oe moved with SCL high"); // R11

  AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    ($past(ctrlState) == ST_CMD && ctrlState != ST_CMD && ctrlState != ST_IDLE)
      |-> !$past(memBusy)) else $error("command taken while busy"); // R9

  AST_COMMIT_ON_STOP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(commitStb) |-> ($past(sclIn) && $past(sdaIn))) else $error("commit without stop"); // R5

  AST_PROT_COMMIT_ON_STOP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(protCommitStb) |-> ($past(sclIn) && $past(sdaIn))) else $error("protection commit without stop"); // R10

  AST_READ_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    readStb |=> (memAddr == $past(memAddr) + STEP)) else $error("read did not advance"); // R7

  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({loadStb, commitStb, readStb, protCtlStb, protDataStb, protCommitStb}))
    else $error("strobes overlap"); // R10

  AST_COMMIT_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    commitStb |=> !commitStb) else $error("commit longer than one cycle"); // R5

endmodule

bind serialMemFront smfChecker #(.AW(AW)) uChk (
  .clk           (clk),
  .rstN          (rstN),
  .sclIn         (sclIn),
  .sdaIn         (sdaIn),
  .memBusy       (memBusy),
  .sdaOe         (sdaOe),
  .memAddr       (memAddr),
  .loadStb       (loadStb),
  .commitStb     (commitStb),
  .readStb       (readStb),
  .protCtlStb    (protCtlStb),
  .protDataStb   (protDataStb),
  .protCommitStb (protCommitStb),
  .ctrlState     (ctrlState)
);

// File: tb/sim_serialMemFront.sv
module sim_serialMemFront;

  localparam int AW = 8;
  localparam int Q  = 4;
  // {address, data} pairs for the write / random-read sweep
  localparam logic [15:0] VEC [8] = '{
    16'h005A, 16'h13C3, 16'h2F01, 16'h47FE,
    16'h8080, 16'h9C77, 16'hD5A5, 16'hFF3E
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic hScl = 1'b1, hSda = 1'b1, memBusy = 1'b0;
  logic sdaOe, sdaLine;
  logic [AW-1:0] memAddr;
  logic [7:0] memWrData, memRdData;
  logic loadStb, commitStb, readStb, protCtlStb, protDataStb, protCommitStb;
  logic [7:0] mem [256];

  assign sdaLine   = hSda & ~sdaOe;
  assign memRdData = mem[memAddr];

  serialMemFront #(.AW(AW), .PAGE_W(3)) u0 (
    .clk(clk), .rstN(rstN), .sclIn(hScl), .sdaIn(sdaLine), .memBusy(memBusy),
    .memRdData(memRdData), .sdaOe(sdaOe), .memAddr(memAddr), .memWrData(memWrData),
    .loadStb(loadStb), .commitStb(commitStb), .readStb(readStb),
    .protCtlStb(protCtlStb), .protDataStb(protDataStb), .protCommitStb(protCommitStb)
  );

  int nChk = 0, nFail = 0;
  int nLoad = 0, nCommit = 0, nRead = 0, nPctl = 0, nPdata = 0, nPcommit = 0;
  logic [7:0] logA [16];
  logic [7:0] lastLoadData, lastPctl;
  logic done = 1'b0;

  // strobe monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      if (loadStb) begin
        mem[memAddr] = memWrData;
        logA[nLoad % 16] = memAddr;
        lastLoadData = memWrData;
        nLoad++;
      end
      if (commitStb)     nCommit++;
      if (readStb)       nRead++;
      if (protCtlStb)    begin nPctl++; lastPctl = memWrData; end
      if (protDataStb)   nPdata++;
      if (protCommitStb) nPcommit++;
    end
  end

  task automatic chkEq(input string tag, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    hSda = 1'b1; waitQ();
    hScl = 1'b1; waitQ();
    hSda = 1'b0; waitQ();
    hScl = 1'b0; waitQ();
  endtask

  task automatic busStop();
    hSda = 1'b0; waitQ();
    hScl = 1'b1; waitQ();
    hSda = 1'b1; waitQ();
  endtask

  task automatic sendBit(input logic b);
    hSda = b;    waitQ();
    hScl = 1'b1; waitQ();
    hScl = 1'b0; waitQ();
  endtask

  task automatic recvBit(output logic b);
    hSda = 1'b1; waitQ();
    hScl = 1'b1; waitQ();
    b = sdaLine;
    hScl = 1'b0; waitQ();
  endtask

  task automatic sendByte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) sendBit(d[i]);
    recvBit(b);
    ack = ~b;
  endtask

  task automatic recvByte(input logic ackIt, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recvBit(b);
      d[i] = b;
    end
    sendBit(~ackIt);
  endtask

  task automatic setAddr(input logic [7:0] a);
    logic ack;
    busStart(); sendByte(8'hA0, ack); sendByte(a, ack);
  endtask

  logic ack;
  logic [7:0] a, d, cw, rd, e0;
  int c0, n0, r0, p0, q0, l0;

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h3C;
    repeat (3) @(negedge clk);
    // reset state
    chkEq("R11 sdaOe in reset", int'(sdaOe), 0);
    chkEq("R3 counter in reset", int'(memAddr), 0);
    chkEq("R5 strobes in reset",
          int'({loadStb, commitStb, readStb, protCtlStb, protDataStb, protCommitStb}), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // table sweep: byte write then random read, command don't-care bits varied
    for (int i = 0; i < 8; i++) begin
      a  = VEC[i][15:8];
      d  = VEC[i][7:0];
      cw = 8'hA0 | 8'(i << 1);
      c0 = nCommit;
      busStart(); sendByte(cw, ack);
      chkEq("R2 write command ack", int'(ack), 1);
      sendByte(a, ack);
      chkEq("R3 address ack", int'(ack), 1);
      sendByte(d, ack);
      chkEq("R4 data ack", int'(ack), 1);
      busStop();
      chkEq("R5 one commit after write", nCommit, c0 + 1);
      chkEq("R4 load address", int'(logA[(nLoad - 1) % 16]), int'(a));
      chkEq("R4 load data", int'(lastLoadData), int'(d));
      setAddr(a); busStart(); sendByte(cw | 8'h01, ack);
      chkEq("R6 read command ack", int'(ack), 1);
      recvByte(1'b0, rd); busStop();
      chkEq("R6 random read data", int'(rd), int'(d));
      chkEq("R5 no commit after read", nCommit, c0 + 1);
    end

    // R1: bytes without a start are ignored
    hScl = 1'b0; waitQ();
    sendByte(8'hA1, ack);
    chkEq("R1 no ack without start", int'(ack), 0);
    busStop();

    // R2: wrong tags
    busStart(); sendByte(8'h61, ack); busStop();
    chkEq("R2 tag 0110 not acked", int'(ack), 0);
    busStart(); sendByte(8'hB0, ack); busStop();
    chkEq("R2 tag 1011 not acked", int'(ack), 0);

    // R9: busy polling
    memBusy = 1'b1; r0 = nRead;
    busStart(); sendByte(8'hA1, ack); busStop();
    chkEq("R9 read command not acked while busy", int'(ack), 0);
    busStart(); sendByte(8'hA0, ack); busStop();
    chkEq("R9 write command not acked while busy", int'(ack), 0);
    chkEq("R9 no fetch while busy", nRead, r0);
    memBusy = 1'b0;
    busStart(); sendByte(8'hA1, ack);
    chkEq("R9 acked once idle", int'(ack), 1);
    recvByte(1'b0, rd); busStop();

    // R7: sequential read with rollover, then current address read
    mem[8'hFE] = 8'h11; mem[8'hFF] = 8'h22; mem[8'h00] = 8'h33; mem[8'h01] = 8'h44;
    r0 = nRead;
    setAddr(8'hFE); busStart(); sendByte(8'hA1, ack);
    recvByte(1'b1, rd); chkEq("R7 sequential byte 0", int'(rd), 8'h11);
    recvByte(1'b1, rd); chkEq("R7 sequential byte 1", int'(rd), 8'h22);
    recvByte(1'b0, rd); chkEq("R7 rollover to 0", int'(rd), 8'h33);
    // R8: released after not-acknowledge, no extra fetch
    waitQ();
    chkEq("R8 released after nack", int'(sdaOe), 0);
    chkEq("R8 fetch count", nRead, r0 + 3);
    busStop();
    busStart(); sendByte(8'hA1, ack); recvByte(1'b0, rd); busStop();
    chkEq("R7 current address read", int'(rd), 8'h44);

    // R4: page write wraps inside the page
    n0 = nLoad; c0 = nCommit;
    setAddr(8'h0E);
    sendByte(8'hC1, ack); sendByte(8'hC2, ack); sendByte(8'hC3, ack);
    busStop();
    chkEq("R4 wrap addr 0", int'(logA[n0 % 16]), 8'h0E);
    chkEq("R4 wrap addr 1", int'(logA[(n0 + 1) % 16]), 8'h0F);
    chkEq("R4 wrap addr 2", int'(logA[(n0 + 2) % 16]), 8'h08);
    chkEq("R5 single commit for page", nCommit, c0 + 1);
    chkEq("R4 counter after wrap", int'(memAddr), 8'h09);

    // R5: repeated start abandons write data
    c0 = nCommit;
    setAddr(8'h30); sendByte(8'h99, ack);
    busStart(); busStop();
    chkEq("R5 abandoned write no commit", nCommit, c0);

    // R10: protection sequence
    c0 = nCommit; n0 = nLoad; p0 = nPctl; q0 = nPdata; l0 = nPcommit;
    setAddr(8'h10);
    busStart(); sendByte(8'hA0, ack);
    chkEq("R10 second write command ack", int'(ack), 1);
    sendByte(8'h01, ack);
    chkEq("R10 control byte ack", int'(ack), 1);
    for (int k = 0; k < 8; k++) sendByte(8'(k + 8'h50), ack);
    chkEq("R10 last protection byte ack", int'(ack), 1);
    busStop();
    chkEq("R10 control strobe", nPctl, p0 + 1);
    chkEq("R10 control value", int'(lastPctl), 8'h01);
    chkEq("R10 protection data strobes", nPdata, q0 + 8);
    chkEq("R10 protection commit", nPcommit, l0 + 1);
    chkEq("R10 no data commit", nCommit, c0);
    chkEq("R10 no data load", nLoad, n0);

    // R12: start in mid byte
    e0 = mem[8'h10];
    busStart(); sendBit(1'b1); sendBit(1'b0); sendBit(1'b1); sendBit(1'b0);
    busStart(); sendByte(8'hA1, ack);
    chkEq("R12 command after mid-byte start", int'(ack), 1);
    recvByte(1'b0, rd); busStop();
    chkEq("R12 read after mid-byte start", int'(rd), int'(e0));
    n0 = nLoad;
    setAddr(8'h20); sendBit(1'b0); sendBit(1'b1); sendBit(1'b1);
    busStart(); busStop();
    chkEq("R12 abandoned byte no load", nLoad, n0);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

endmodule